// File: doc/BRIEF.md
# Bell-202 AFSK Tone Modulator

This block turns a stream of bytes into 8-bit unsigned audio samples by phase-continuous frequency-shift keying between a 1200 Hz mark tone and a 2200 Hz space tone. A phase accumulator is advanced once per DAC sample tick by a tone-dependent increment. Its value indexes a sine table that stores only the first quarter of the wave; the other three quarters are derived by mirroring and inversion.

Bits are sent least significant first with NRZI coding. HDLC zero insertion is applied to ordinary data. A burst of flag bytes leads each transmission and another burst follows it. An escape code lets a data byte that equals a flag or abort code pass with normal stuffing. One start pulse runs a whole transmission. The block stops by itself at a byte boundary once the input has run dry and the trailing flags are spent.

Top module: `afsk_tone_mod`

## Requirements
- R1: After reset, `busy_o` is 0, `sample_valid_o` is 0, `sample_o` is 128 and `in_ready_o` is 1.
- R2: A start pulse while idle raises `busy_o` one cycle later. While busy, each `sample_tick_i` produces exactly one sample, with `sample_valid_o` high for one cycle in the cycle after the tick. No sample appears while idle.
- R3: The phase accumulator is 9 bits and wraps modulo 512. Each sample adds 64 on the mark tone or 117 on the space tone, where each step is round(512 × f / 9600). Every transmission begins on the mark tone.
- R4: The quarter table entry i (0..127) is 128 + round(127 × sin(π·i/256)). For a phase p, take q = p mod 256. The index is q when q < 128, and 255 − q otherwise. The sample is the entry when p < 256, and 255 minus the entry otherwise. The phase used is the value after the increment.
- R5: Each bit lasts 8 samples, and bits go out LSB first. A 1 keeps the tone and a 0 swaps mark and space, starting from the first sample of that bit.
- R6: In a stuffed byte, once five 1 bits in a row have been sent, an extra 0 bit (tone swap) goes out before the next bit. The ones count is cleared at each byte start, after any 0 and after an inserted 0.
- R7: The bytes 0x7E (flag) and 0x7F (abort), when taken directly from the input, are sent without zero insertion. All other bytes are stuffed.
- R8: The escape byte 0x1B is never sent. The byte waiting behind it is consumed and sent stuffed, whatever its value. If no byte is waiting, the transmission ends on that tick: no sample is produced and `busy_o` falls.
- R9: Each transmission opens with round(PREAMBLE_MS × 1200 / 8000) flag bytes (3 by default), before any input byte is taken.
- R10: At a byte boundary with no byte held and the trailer count nonzero, a flag byte is sent and the count drops by one. The count starts at round(TRAILER_MS × 1200 / 8000), which is 3 by default. With no byte held and the count at zero, the transmission ends on that tick with no sample.
- R11: The phase carries over from one transmission to the next. A start does not clear it.
- R12: A byte is accepted when `in_valid_i` and `in_ready_o` are both high. One accepted byte is held. While the block is idle and a byte is held, `in_ready_o` is 0. The input counts as empty exactly when no byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; begins a transmission when idle |
| sample_tick_i | input | 1 | DAC sample-rate enable, one pulse per output sample |
| in_data_i | input | 8 | Byte to transmit |
| in_valid_i | input | 1 | Byte on `in_data_i` is valid |
| in_ready_o | output | 1 | Block accepts the byte this cycle |
| sample_o | output | 8 | Unsigned audio sample |
| sample_valid_o | output | 1 | New sample on `sample_o` |
| busy_o | output | 1 | Transmission in progress |

## Verification
A new sample is due in the cycle after the tick that produced it. The bench therefore reads `sample_valid_o` and `sample_o` at every falling edge and compares each strobe, in order, with a queue of samples computed beforehand from R3 to R10. `busy_o` is due one cycle after the start pulse and falls in the cycle after the tick that ends the transmission. Both are sampled at the next falling edge. Input handshakes are decided shortly before the rising edge, once the random tick for that cycle has settled. So every input decision and every output check sits half a period away from the edge that acts on it.

// File: rtl/afsk_pkg.sv
// afsk_pkg: byte codes and elaboration helpers shared by the tone modulator.
// Assumes byte codes are fixed by the link layer and never change at run time.
package afsk_pkg;
    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'h7F;
    localparam logic [7:0] ESC_BYTE   = 8'h1B;

    // Integer division rounded to nearest, for elaboration-time constants
    function automatic int div_round(input int num, input int den);
        return (num + den / 2) / den;
    endfunction
endpackage

// File: rtl/afsk_sine_lut.sv
// afsk_sine_lut: maps a phase to an unsigned 8-bit sine level.
// Stores only the rising quarter wave (computed at elaboration) and derives the
// other quarters by index mirroring and amplitude inversion. Purely combinational.
module afsk_sine_lut #(
    parameter int PHASE_BITS = 9
) (
    input  logic [PHASE_BITS-1:0] phase_i,
    output logic [7:0]            level_o
);
    localparam int QW     = PHASE_BITS - 2;
    localparam int QDEPTH = 1 << QW;

    logic [7:0]    quarter [QDEPTH];
    logic [QW-1:0] idx;
    logic [7:0]    base;

    // Quarter-wave entries: 128 + round(127*sin(pi/2 * i/QDEPTH))
    for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_tab
        localparam int LEVEL = 128 + $rtoi(127.0 * $sin(3.141592653589793 * real'(gi)
                                                         / real'(2 * QDEPTH)) + 0.5);
        assign quarter[gi] = 8'(LEVEL);
    end

    // Mirror the index in the falling quarter, invert the level in the lower half
    always_comb begin
        idx     = phase_i[PHASE_BITS-2] ? ~phase_i[QW-1:0] : phase_i[QW-1:0];
        base    = quarter[idx];
        level_o = phase_i[PHASE_BITS-1] ? (8'd255 - base) : base;
    end
endmodule

// File: rtl/afsk_dds.sv
// afsk_dds: phase accumulator plus registered sample output.
// Assumes step_i is high at most once per sample tick; space_i selects the
// increment for that step. The sample reflects the phase after the increment.
module afsk_dds #(
    parameter int PHASE_BITS = 9,
    parameter int MARK_INC   = 64,
    parameter int SPACE_INC  = 117
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       space_i,
    output logic [7:0] sample_o,
    output logic       valid_o
);
    localparam logic [PHASE_BITS-1:0] MARK_STEP  = PHASE_BITS'(MARK_INC);
    localparam logic [PHASE_BITS-1:0] SPACE_STEP = PHASE_BITS'(SPACE_INC);

    logic [PHASE_BITS-1:0] acc_q;
    logic [PHASE_BITS-1:0] acc_n;
    logic [7:0]            level;

    // Next phase, wrapping naturally at the accumulator width
    always_comb acc_n = acc_q + (space_i ? SPACE_STEP : MARK_STEP);

    afsk_sine_lut #(.PHASE_BITS(PHASE_BITS)) u_lut (
        .phase_i (acc_n),
        .level_o (level)
    );

    // Advance phase and capture the sample on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            sample_o <= 8'd128;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= step_i;
            if (step_i) begin
                acc_q    <= acc_n;
                sample_o <= level;
            end
        end
    end
endmodule

// File: rtl/afsk_byte_hold.sv
// afsk_byte_hold: one-byte holding stage in front of the bit engine.
// take_i consumes the held byte; take_next_i additionally consumes the byte
// presented on the input in the same cycle (escape handling). The engine only
// raises take_next_i when in_valid_i is high.
module afsk_byte_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    input  logic       take_i,
    input  logic       take_next_i,
    output logic       head_valid_o,
    output logic [7:0] head_o
);
    // Accept whenever the slot is free or being emptied this cycle
    always_comb in_ready_o = !head_valid_o || take_i;

    // Refill or drain the holding slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_valid_o <= 1'b0;
            head_o       <= '0;
        end else if (take_next_i) begin
            head_valid_o <= 1'b0;
        end else if (in_valid_i && in_ready_o) begin
            head_valid_o <= 1'b1;
            head_o       <= in_data_i;
        end else if (take_i) begin
            head_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/afsk_tx_ctrl.sv
// afsk_tx_ctrl: per-tick bit engine. At each bit boundary it picks the next
// byte (preamble flag, held byte, escaped byte or trailer flag) and decides
// the next line bit with NRZI and zero insertion. It issues one DDS step per
// tick while busy, and decides to stop only at a byte boundary.
module afsk_tx_ctrl
    import afsk_pkg::*;
#(
    parameter int SPB       = 8,
    parameter int PRE_BYTES = 3,
    parameter int TRL_BYTES = 3,
    parameter int CNT_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       head_valid_i,
    input  logic [7:0] head_i,
    input  logic       next_valid_i,
    input  logic [7:0] next_i,
    output logic       take_o,
    output logic       take_next_o,
    output logic       step_o,
    output logic       space_o,
    output logic       busy_o
);
    localparam int SCW = (SPB > 1) ? $clog2(SPB) : 1;
    localparam logic [SCW-1:0]   SC_LAST = SCW'(SPB - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             busy_q, tone_q, act_q, stuff_q;
    logic [CNT_W-1:0] pre_q, trl_q, pre_n, trl_n;
    logic [SCW-1:0]   scnt_q;
    logic [2:0]       pos_q, ones_q, pos_n, ones_n, cur_pos, cur_ones;
    logic [7:0]       byte_q, nb;
    logic             nstuff, loaded, stop, flip, act_n, tick_run, need_bit;

    assign busy_o = busy_q;

    // Byte selection, stop decision and next-bit decision for this tick
    always_comb begin
        take_o      = 1'b0;
        take_next_o = 1'b0;
        stop        = 1'b0;
        loaded      = 1'b0;
        nb          = byte_q;
        nstuff      = stuff_q;
        pre_n       = pre_q;
        trl_n       = trl_q;
        flip        = 1'b0;
        ones_n      = ones_q;
        pos_n       = pos_q;
        act_n       = act_q;
        tick_run    = tick_i && busy_q;
        need_bit    = tick_run && (scnt_q == '0);

        if (need_bit && !act_q) begin
            if (pre_q != '0) begin
                nb     = FLAG_BYTE;
                nstuff = 1'b0;
                loaded = 1'b1;
                pre_n  = pre_q - CNT_ONE;
            end else if (!head_valid_i) begin
                if (trl_q == '0) begin
                    stop = 1'b1;
                end else begin
                    nb     = FLAG_BYTE;
                    nstuff = 1'b0;
                    loaded = 1'b1;
                    trl_n  = trl_q - CNT_ONE;
                end
            end else begin
                take_o = 1'b1;
                if (head_i == ESC_BYTE) begin
                    if (next_valid_i) begin
                        take_next_o = 1'b1;
                        nb          = next_i;
                        nstuff      = 1'b1;
                        loaded      = 1'b1;
                    end else begin
                        stop = 1'b1;
                    end
                end else begin
                    nb     = head_i;
                    nstuff = !(head_i == FLAG_BYTE || head_i == ABORT_BYTE);
                    loaded = 1'b1;
                end
            end
        end

        cur_pos  = loaded ? 3'd0 : pos_q;
        cur_ones = loaded ? 3'd0 : ones_q;

        if (need_bit && !stop) begin
            if (nstuff && cur_ones >= 3'd5) begin
                flip   = 1'b1;
                ones_n = 3'd0;
                pos_n  = cur_pos;
                act_n  = 1'b1;
            end else begin
                if (nb[cur_pos]) begin
                    ones_n = cur_ones + 3'd1;
                end else begin
                    flip   = 1'b1;
                    ones_n = 3'd0;
                end
                pos_n = cur_pos + 3'd1;
                act_n = (cur_pos != 3'd7);
            end
        end

        step_o  = tick_run && !stop;
        space_o = tone_q ^ flip;
    end

    // Engine state: run control, byte counters, bit position and tone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            tone_q  <= 1'b0;
            act_q   <= 1'b0;
            stuff_q <= 1'b0;
            pre_q   <= '0;
            trl_q   <= '0;
            scnt_q  <= '0;
            pos_q   <= '0;
            ones_q  <= '0;
            byte_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            tone_q <= 1'b0;
            act_q  <= 1'b0;
            pre_q  <= CNT_W'(PRE_BYTES);
            trl_q  <= CNT_W'(TRL_BYTES);
            scnt_q <= '0;
            pos_q  <= '0;
            ones_q <= '0;
        end else begin
            if (stop) busy_q <= 1'b0;
            pre_q <= pre_n;
            trl_q <= trl_n;
            if (need_bit && !stop) begin
                byte_q  <= nb;
                stuff_q <= nstuff;
                ones_q  <= ones_n;
                pos_q   <= pos_n;
                act_q   <= act_n;
            end
            if (step_o) begin
                tone_q <= space_o;
                scnt_q <= (scnt_q == '0) ? SC_LAST : scnt_q - SCW'(1);
            end
        end
    end
endmodule

// File: rtl/afsk_tone_mod.sv
// afsk_tone_mod: top of the AFSK tone modulator. Wires the holding stage,
// the bit engine and the DDS. Assumes DAC_RATE is an integer multiple of
// BIT_RATE, and that sample_tick_i pulses at the DAC rate.
module afsk_tone_mod
    import afsk_pkg::*;
#(
    parameter int DAC_RATE    = 9600,
    parameter int BIT_RATE    = 1200,
    parameter int MARK_HZ     = 1200,
    parameter int SPACE_HZ    = 2200,
    parameter int PHASE_BITS  = 9,
    parameter int PREAMBLE_MS = 20,
    parameter int TRAILER_MS  = 20,
    parameter int CNT_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sample_tick_i,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    output logic [7:0] sample_o,
    output logic       sample_valid_o,
    output logic       busy_o
);
    localparam int SPB       = DAC_RATE / BIT_RATE;
    localparam int MARK_INC  = div_round((1 << PHASE_BITS) * MARK_HZ, DAC_RATE);
    localparam int SPACE_INC = div_round((1 << PHASE_BITS) * SPACE_HZ, DAC_RATE);
    localparam int PRE_BYTES = div_round(PREAMBLE_MS * BIT_RATE, 8000);
    localparam int TRL_BYTES = div_round(TRAILER_MS * BIT_RATE, 8000);

    logic       take, take_next, head_valid, step, space;
    logic [7:0] head;

    afsk_byte_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data_i    (in_data_i),
        .in_valid_i   (in_valid_i),
        .in_ready_o   (in_ready_o),
        .take_i       (take),
        .take_next_i  (take_next),
        .head_valid_o (head_valid),
        .head_o       (head)
    );

    afsk_tx_ctrl #(
        .SPB       (SPB),
        .PRE_BYTES (PRE_BYTES),
        .TRL_BYTES (TRL_BYTES),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tick_i       (sample_tick_i),
        .head_valid_i (head_valid),
        .head_i       (head),
        .next_valid_i (in_valid_i),
        .next_i       (in_data_i),
        .take_o       (take),
        .take_next_o  (take_next),
        .step_o       (step),
        .space_o      (space),
        .busy_o       (busy_o)
    );

    afsk_dds #(
        .PHASE_BITS (PHASE_BITS),
        .MARK_INC   (MARK_INC),
        .SPACE_INC  (SPACE_INC)
    ) u_dds (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .space_i  (space),
        .sample_o (sample_o),
        .valid_o  (sample_valid_o)
    );
endmodule

// File: rtl/afsk_tone_mod_chk.sv
// afsk_tone_mod_chk: protocol and state assertions for afsk_tone_mod,
// attached by bind. Observes ports and the engine's stuffing state.
module afsk_tone_mod_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       sample_tick_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       sample_valid_o,
    input logic       busy_o,
    input logic       stuff_en,
    input logic [2:0] ones
);
    // R2: a sample strobe only follows a tick taken while busy
    a_r2_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> $past(sample_tick_i && busy_o));

    // R2: busy only rises after a start pulse
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R10: the transmission ends only on a tick
    a_r10_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(sample_tick_i));

    // R6: in stuffed data the ones run never exceeds five
    a_r6_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_en |-> (ones <= 3'd5));

    // R12: while idle, a byte accepted last cycle is held and blocks further input
    a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(in_valid_i && in_ready_o)) |-> !in_ready_o);
endmodule

bind afsk_tone_mod afsk_tone_mod_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sample_tick_i  (sample_tick_i),
    .in_valid_i     (in_valid_i),
    .in_ready_o     (in_ready_o),
    .sample_valid_o (sample_valid_o),
    .busy_o         (busy_o),
    .stuff_en       (u_ctrl.stuff_q),
    .ones           (u_ctrl.ones_q)
);

// File: tb/test_afsk_tone_mod.sv
`timescale 1ns/100ps
module test_afsk_tone_mod;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] sample;
    logic       sample_valid;
    logic       busy;

    always #2.5 clk = ~clk;

    afsk_tone_mod i_afsk_tone_mod (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .sample_tick_i  (tick),
        .in_data_i      (in_data),
        .in_valid_i     (in_valid),
        .in_ready_o     (in_ready),
        .sample_o       (sample),
        .sample_valid_o (sample_valid),
        .busy_o         (busy)
    );

    localparam int MARK_STEP  = (512 * 1200 + 4800) / 9600;
    localparam int SPACE_STEP = (512 * 2200 + 4800) / 9600;
    localparam int PRE_N      = (20 * 1200 + 4000) / 8000;
    localparam int TRL_N      = (20 * 1200 + 4000) / 8000;

    int         n_chk = 0;
    int         n_fail = 0;
    int         exp_q[$];
    int         m_acc = 0;
    int         m_tone = 0;
    int         e_v;
    int         hs_cnt = 0;
    bit         stream_done = 1'b0;
    string      tag = "R3";
    logic [7:0] frame[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // R4: reference sine level for a phase
    function automatic int sine_ref(input int ph);
        int q = ph % 256;
        int n = (q >= 128) ? 255 - q : q;
        int v = 128 + $rtoi(127.0 * $sin(3.141592653589793 * real'(n) / 256.0) + 0.5);
        return (ph >= 256) ? 255 - v : v;
    endfunction

    // R3 R5: one line bit, 8 samples
    task automatic emit_bit(input bit b);
        if (!b) m_tone = m_tone ^ 1;
        repeat (8) begin
            m_acc = (m_acc + (m_tone != 0 ? SPACE_STEP : MARK_STEP)) % 512;
            exp_q.push_back(sine_ref(m_acc));
        end
    endtask

    // R6: one byte LSB first, with optional zero insertion
    task automatic emit_byte(input logic [7:0] v, input bit st);
        int ones = 0;
        for (int i = 0; i < 8; i++) begin
            if (st && ones >= 5) begin
                emit_bit(1'b0);
                ones = 0;
            end
            emit_bit(v[i]);
            ones = v[i] ? ones + 1 : 0;
        end
    endtask

    // R7 R8 R9 R10: expected sample stream for the current frame
    task automatic build_expected();
        int i = 0;
        m_tone = 0;
        for (int k = 0; k < PRE_N; k++) emit_byte(8'h7E, 1'b0);
        while (i < frame.size()) begin
            if (frame[i] == 8'h1B) begin
                if (i + 1 < frame.size()) begin
                    emit_byte(frame[i+1], 1'b1);
                    i += 2;
                end else begin
                    return;
                end
            end else begin
                emit_byte(frame[i], !(frame[i] == 8'h7E || frame[i] == 8'h7F));
                i++;
            end
        end
        for (int k = 0; k < TRL_N; k++) emit_byte(8'h7E, 1'b0);
    endtask

    // R12: present frame bytes, decide handshake just before the rising edge
    task automatic stream_bytes();
        for (int k = 0; k < frame.size(); k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frame[k];
            forever begin
                #1;
                if (in_ready) break;
                @(negedge clk);
            end
            @(posedge clk);
            hs_cnt++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Random tick enable, driven away from the active edge
    always @(negedge clk) tick <= rst_n ? ($urandom_range(0, 2) != 0) : 1'b0;

    // R2 R3 R4 R5: compare every sample strobe against the expected queue
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected sample", int'(sample), -1);
            end else begin
                e_v = exp_q.pop_front();
                chk(int'(sample) == e_v, tag, "sample", int'(sample), e_v);
            end
        end
    end

    task automatic run_frame(input string t);
        int w = 0;
        tag = t;
        build_expected();
        hs_cnt = 0;
        stream_done = 1'b0;
        fork
            begin
                stream_bytes();
                stream_done = 1'b1;
            end
        join_none
        if (frame.size() > 0) begin
            wait (hs_cnt >= 1);
            @(negedge clk);
            #1;
            chk(in_ready == 1'b0, "R12", "ready while idle and holding", int'(in_ready), 0);
        end else begin
            @(negedge clk);
            #1;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (busy && w < 40000) begin
            @(negedge clk);
            w++;
        end
        chk(busy == 1'b0, "R10", "transmission ended", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "samples still owed", exp_q.size(), 0);
        chk(stream_done, "R12", "all bytes accepted", int'(stream_done), 1);
        exp_q.delete();
        wait (stream_done);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd7041));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(sample_valid == 1'b0, "R1", "sample_valid", int'(sample_valid), 0);
        chk(sample == 8'd128, "R1", "sample", int'(sample), 128);
        chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

        // R2: ticks while idle give no samples
        cnt = 0;
        repeat (30) begin
            @(negedge clk);
            if (sample_valid) cnt++;
        end
        chk(cnt == 0, "R2", "idle samples", cnt, 0);

        frame = '{8'hA5};                       run_frame("R3/R4/R5");
        frame = '{8'hFF, 8'hFF, 8'hF8};         run_frame("R6");
        frame = '{8'h7E, 8'h7F, 8'h00};         run_frame("R7");
        frame = '{8'h1B, 8'h7E, 8'h1B, 8'h1B};  run_frame("R8");
        frame = '{8'h55, 8'h1B};                run_frame("R8 stop");
        frame = '{};                            run_frame("R9/R10");

        // R11: phase carries across frames; random content with special codes
        for (int f = 0; f < 8; f++) begin
            int n = $urandom_range(0, 6);
            frame = '{};
            for (int k = 0; k < n; k++) begin
                case ($urandom_range(0, 7))
                    0: frame.push_back(8'h1B);
                    1: frame.push_back(8'h7E);
                    2: frame.push_back(8'hFF);
                    3: frame.push_back(8'h7F);
                    default: frame.push_back(8'($urandom_range(0, 255)));
                endcase
            end
            run_frame("R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule